// File: doc/BRIEF.md
# Initiator Burst Latency Timer

This block decides when a bus initiator must cut a burst short on a shared parallel bus with an active-low grant. When the initiator opens a transaction, a programmable down-counter is loaded and then counts clock cycles. The initiator must give up the bus only when that counter has run out and the arbiter has also taken the grant away. Either condition on its own is not enough.

Once both conditions hold, the block marks the current data phase as the final one, so the initiator can deassert its frame signal while its ready signal is still asserted. A write-and-invalidate command is handled differently. It keeps bursting until the last data phase of the current cache line, which is found by counting completed data phases. The initiator can also end a burst on its own at any time. The block ignores addresses, data and target replies.

Top module: `lat_term_ctl`

## Requirements
- R1: While reset is active and after it is released, with no transaction started, both `term_req_o` and `frame_last_o` are low.
- R2: On the clock edge where `start_i` is high, the timer loads `lt_reload_i`. It then drops by one on each later edge. With the grant removed, `term_req_o` first rises exactly `lt_reload_i` cycles after the start edge.
- R3: `term_req_o` is high only while a transaction is open, the timer is at zero and `gnt_n_i` is high. While `gnt_n_i` stays low, it stays low no matter how long the timer has been at zero.
- R4: For any command other than write-and-invalidate (`cmd_i` value 4'b1111, sampled at start), `frame_last_o` is high in every cycle where `term_req_o` is high.
- R5: For a write-and-invalidate transaction, a timeout marks only the cache-line boundary phase as last. That phase has a completed-phase count within the line equal to `line_size_i` minus one. A `line_size_i` of 0 or 1 makes every phase a boundary.
- R6: The in-line phase count clears at start and advances only on edges where `phase_done_i` is high. Stalled cycles do not move the boundary.
- R7: `last_req_i` high during an open transaction forces `frame_last_o` high, whether or not the timer has expired.
- R8: A data phase that completes (`phase_done_i` high) while `frame_last_o` is high closes the transaction. From the next cycle both outputs stay low until the next start.
- R9: The timer stops at zero instead of wrapping. With the grant removed and no phase completing, `term_req_o` stays high for longer than 256 cycles.
- R10: Each new start reloads the timer, so an expiry in one transaction does not carry into the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Initiator opens a transaction this cycle |
| cmd_i | input | CMD_W (4) | Bus command, sampled with `start_i` |
| lt_reload_i | input | TMR_W (8) | Programmed latency timer value |
| line_size_i | input | LINE_W (8) | Cache-line size in data phases |
| phase_done_i | input | 1 | Current data phase completes this cycle |
| last_req_i | input | 1 | Initiator wants this phase to be its last |
| gnt_n_i | input | 1 | Active-low bus grant from the arbiter |
| term_req_o | output | 1 | Timer expired and grant removed |
| frame_last_o | output | 1 | Current data phase is the final one (frame may drop) |

## Verification
The timer, the phase count and the open-transaction flag are all loaded on the clock edge that samples their inputs. The two outputs are combinational on that state and on the current grant and last-request inputs. So a result caused by a start or a completed phase is due one edge later, while a change of `gnt_n_i` or `last_req_i` shows up in the same cycle. The bench drives inputs and samples outputs one time unit after the rising edge. It counts the cycles from the start edge to find the cycle on which `term_req_o` should rise and the phase on which `frame_last_o` should rise. For grant and last-request changes, it samples again a further time unit later, within the same cycle.

// File: rtl/lat_pkg.sv
package lat_pkg;
   localparam int unsigned LAT_CMD_W = 4;
   localparam logic [LAT_CMD_W-1:0] LAT_CMD_WR_INV = 4'b1111;
endpackage

// File: rtl/lat_timer.sv
module lat_timer #(
   parameter int unsigned TMR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             run_i,
   input  logic [TMR_W-1:0] reload_i,
   output logic             zero_o
);
   localparam logic [TMR_W-1:0] ZERO = '0;
   localparam logic [TMR_W-1:0] ONE  = {{(TMR_W-1){1'b0}}, 1'b1};

   logic [TMR_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                       cnt_q <= ZERO;
      else if (load_i)                  cnt_q <= reload_i;
      else if (run_i && cnt_q != ZERO)  cnt_q <= cnt_q - ONE;
   end

   assign zero_o = (cnt_q == ZERO);

   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> cnt_q == $past(reload_i));
   p_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !load_i && cnt_q != ZERO) |=> cnt_q == $past(cnt_q) - ONE);
   p_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && cnt_q == ZERO) |=> cnt_q == ZERO);
endmodule

// File: rtl/lat_line_track.sv
module lat_line_track #(
   parameter int unsigned LINE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              adv_i,
   input  logic [LINE_W-1:0] size_i,
   output logic              end_o
);
   localparam logic [LINE_W-1:0] ONE = {{(LINE_W-1){1'b0}}, 1'b1};

   logic [LINE_W-1:0] ph_q;
   logic              small_line;

   assign small_line = (size_i <= ONE);
   assign end_o      = small_line || (ph_q >= size_i - ONE);

   always_ff @(posedge clk) begin
      if (!rst_n)        ph_q <= '0;
      else if (clear_i)  ph_q <= '0;
      else if (adv_i)    ph_q <= end_o ? '0 : ph_q + ONE;
   end

   p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> ph_q == '0);
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear_i && !adv_i) |=> $stable(ph_q));
endmodule

// File: rtl/lat_term_dec.sv
module lat_term_dec (
   input  logic busy_i,
   input  logic expired_i,
   input  logic gnt_n_i,
   input  logic wr_inv_i,
   input  logic line_end_i,
   input  logic last_req_i,
   output logic term_req_o,
   output logic frame_last_o
);
   logic may_stop;

   assign term_req_o   = busy_i && expired_i && gnt_n_i;
   assign may_stop     = !wr_inv_i || line_end_i;
   assign frame_last_o = busy_i && (last_req_i || (term_req_o && may_stop));
endmodule

// File: rtl/lat_term_ctl.sv
module lat_term_ctl
   import lat_pkg::*;
#(
   parameter int unsigned TMR_W  = 8,
   parameter int unsigned LINE_W = 8,
   parameter int unsigned CMD_W  = LAT_CMD_W,
   parameter logic [CMD_W-1:0] WR_INV_CODE = LAT_CMD_WR_INV,
   parameter bit          WR_INV_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CMD_W-1:0]  cmd_i,
   input  logic [TMR_W-1:0]  lt_reload_i,
   input  logic [LINE_W-1:0] line_size_i,
   input  logic              phase_done_i,
   input  logic              last_req_i,
   input  logic              gnt_n_i,
   output logic              term_req_o,
   output logic              frame_last_o
);
   generate
      if (TMR_W < 2)  begin : g_bad_tmr  $error("TMR_W must be at least 2");  end
      if (LINE_W < 1) begin : g_bad_line $error("LINE_W must be at least 1"); end
      if (CMD_W < 1)  begin : g_bad_cmd  $error("CMD_W must be at least 1");  end
   endgenerate

   logic busy_q, wr_inv_q, tmr_zero, line_end, term_req, frame_last, closing;

   assign closing = busy_q && phase_done_i && frame_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         wr_inv_q <= 1'b0;
      end else if (start_i) begin
         busy_q   <= 1'b1;
         wr_inv_q <= WR_INV_EN && (cmd_i == WR_INV_CODE);
      end else if (closing) begin
         busy_q   <= 1'b0;
      end
   end

   lat_timer #(.TMR_W(TMR_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (start_i),
      .run_i    (busy_q),
      .reload_i (lt_reload_i),
      .zero_o   (tmr_zero)
   );

   generate
      if (WR_INV_EN) begin : g_line
         lat_line_track #(.LINE_W(LINE_W)) u_line (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear_i (start_i),
            .adv_i   (busy_q && phase_done_i),
            .size_i  (line_size_i),
            .end_o   (line_end)
         );
      end else begin : g_noline
         assign line_end = 1'b1;
      end
   endgenerate

   lat_term_dec u_dec (
      .busy_i       (busy_q),
      .expired_i    (tmr_zero),
      .gnt_n_i      (gnt_n_i),
      .wr_inv_i     (wr_inv_q),
      .line_end_i   (line_end),
      .last_req_i   (last_req_i),
      .term_req_o   (term_req),
      .frame_last_o (frame_last)
   );

   assign term_req_o   = term_req;
   assign frame_last_o = frame_last;

   p_grant_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !gnt_n_i |-> !term_req_o);
   p_plain_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (term_req_o && !wr_inv_q) |-> frame_last_o);
   p_line_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_last_o && wr_inv_q && !last_req_i) |-> line_end);
   p_own_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && last_req_i) |-> frame_last_o);
   p_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (closing && !start_i) |=> (!frame_last_o && !term_req_o));
endmodule

// File: tb/lat_term_ctl_test.sv
module lat_term_ctl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [3:0] cmd_i = 4'h7;
   logic [7:0] lt_reload_i = 8'd0;
   logic [7:0] line_size_i = 8'd4;
   logic       phase_done_i = 1'b0;
   logic       last_req_i = 1'b0;
   logic       gnt_n_i = 1'b0;
   logic       term_req_o, frame_last_o;

   int n_run = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   lat_term_ctl uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_i(cmd_i),
      .lt_reload_i(lt_reload_i), .line_size_i(line_size_i),
      .phase_done_i(phase_done_i), .last_req_i(last_req_i), .gnt_n_i(gnt_n_i),
      .term_req_o(term_req_o), .frame_last_o(frame_last_o)
   );

   // vector: reload, write-and-invalidate flag, line size, expected last phase index
   localparam logic [24:0] VEC [8] = '{
      {8'd3,  1'b0, 8'd4, 8'd3},
      {8'd3,  1'b1, 8'd4, 8'd3},
      {8'd5,  1'b1, 8'd4, 8'd7},
      {8'd0,  1'b0, 8'd8, 8'd0},
      {8'd0,  1'b1, 8'd8, 8'd7},
      {8'd10, 1'b1, 8'd1, 8'd10},
      {8'd9,  1'b1, 8'd0, 8'd9},
      {8'd6,  1'b1, 8'd3, 8'd8}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic open_txn(input logic [7:0] rl, input bit wi, input logic [7:0] cls);
      start_i = 1'b1;
      lt_reload_i = rl;
      cmd_i = wi ? 4'b1111 : 4'b0111;
      line_size_i = cls;
      tick();
      start_i = 1'b0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      // R1: reset state
      repeat (3) tick();
      chk(!term_req_o && !frame_last_o, "R1 in reset", term_req_o + frame_last_o, 0);
      rst_n = 1'b1;
      gnt_n_i = 1'b1;
      repeat (3) tick();
      chk(!term_req_o && !frame_last_o, "R1 idle after reset", term_req_o + frame_last_o, 0);

      // table walk: phase completes every cycle, grant removed; R2 R4 R5 R8 R10
      for (int v = 0; v < 8; v++) begin
         int rl, ex, got_t, got_f;
         rl = int'(VEC[v][24:17]);
         ex = int'(VEC[v][7:0]);
         got_t = -1;
         got_f = -1;
         gnt_n_i = 1'b1;
         open_txn(VEC[v][24:17], VEC[v][16], VEC[v][15:8]);
         phase_done_i = 1'b1;
         for (int t = 0; t < 40; t++) begin
            if (term_req_o && got_t < 0) got_t = t;
            if (frame_last_o) begin got_f = t; break; end
            tick();
         end
         chk(got_t == rl, "R2 R10 expiry cycle", got_t, rl);
         chk(got_f == ex, "R4 R5 last phase index", got_f, ex);
         tick();
         chk(!frame_last_o && !term_req_o, "R8 closed after last phase",
             frame_last_o + term_req_o, 0);
         phase_done_i = 1'b0;
         tick();
      end

      // R3 and R9: grant kept, timer long expired, then grant removed
      gnt_n_i = 1'b0;
      open_txn(8'd2, 1'b0, 8'd4);
      for (int t = 0; t < 12; t++) begin
         chk(!term_req_o, "R3 grant held no term", term_req_o, 0);
         tick();
      end
      gnt_n_i = 1'b1;
      #1;
      chk(term_req_o, "R3 term on grant loss", term_req_o, 1);
      chk(frame_last_o, "R4 frame last with term", frame_last_o, 1);
      for (int t = 0; t < 300; t++) begin
         tick();
         if (!term_req_o) begin chk(1'b0, "R9 saturated timer", 0, 1); break; end
      end
      chk(term_req_o, "R9 still expired after 300", term_req_o, 1);
      phase_done_i = 1'b1;
      tick();
      phase_done_i = 1'b0;
      chk(!term_req_o && !frame_last_o, "R8 closed", term_req_o + frame_last_o, 0);

      // R3 and R7: grant removed but timer not expired; own last request
      open_txn(8'd50, 1'b0, 8'd4);
      phase_done_i = 1'b1;
      for (int t = 0; t < 10; t++) begin
         chk(!term_req_o && !frame_last_o, "R3 timer running no term",
             term_req_o + frame_last_o, 0);
         tick();
      end
      last_req_i = 1'b1;
      #1;
      chk(frame_last_o && !term_req_o, "R7 own last phase", frame_last_o, 1);
      tick();
      last_req_i = 1'b0;
      phase_done_i = 1'b0;
      chk(!frame_last_o, "R8 closed after own last", frame_last_o, 0);

      // R6: stalls do not move the cache-line boundary
      open_txn(8'd0, 1'b1, 8'd4);
      for (int t = 0; t < 5; t++) begin
         chk(term_req_o && !frame_last_o, "R6 stall keeps boundary",
             frame_last_o, 0);
         tick();
      end
      phase_done_i = 1'b1;
      begin
         int got;
         got = -1;
         for (int t = 0; t < 10; t++) begin
            if (frame_last_o) begin got = t; break; end
            tick();
         end
         chk(got == 3, "R6 boundary after three phases", got, 3);
      end
      tick();
      phase_done_i = 1'b0;
      chk(!frame_last_o, "R8 closed after line", frame_last_o, 0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule